// File: doc/BRIEF.md
# Weighted-Mask Block Variance Engine

This engine scores a prediction against a pre-weighted source over one rectangular block of pixels, as needed when a motion search for overlapped-block compensation compares candidates. For each pixel it receives an 8-bit unsigned predicted sample, a 32-bit signed weighted-source word and a 32-bit signed mask weight. It forms the residual `wsrc - pred * mask`, scales it down by 4096 with symmetric rounding, and adds the scaled residual to a signed sum and its square to an error-energy total.

A run opens with a one-cycle start pulse that carries the block width and height. Pixels then stream in raster order over a valid/ready pair, one per cycle. After the last pixel the pipeline drains. A shift-subtract divider then removes the squared mean, and the block reports both the squared-error total and the variance with a one-cycle done pulse. A start with a size outside the legal set raises an error pulse and no block is run.

Top module: `wmv_top`

## Requirements
- R1: A start pulse taken in idle is legal only when {width, height} is one of these pairs: 4x4, 4x8, 4x16, 8x4, 8x8, 8x16, 8x32, 16x4, 16x8, 16x16, 16x32, 16x64, 32x8, 32x16, 32x32, 32x64, 64x16, 64x32, 64x64, 64x128, 128x64 or 128x128. For any other pair, `size_err` is high for exactly the cycle after the start, `px_ready` stays low, and `sse_out` and `var_out` keep their values.
- R2: The per-pixel residual is d = wsrc - pred * mask, taken modulo 2^32 as a signed 32-bit value, with pred zero-extended.
- R3: The scaled residual is d / 4096 rounded to nearest, with exact halves rounded away from zero (so -2048 gives -1, 2048 gives 1, -6144 gives -2).
- R4: The sum is a signed 32-bit accumulator of scaled residuals. `sse_out` is an unsigned 32-bit accumulator of their squares. Both wrap modulo 2^32.
- R5: `var_out` = sse - floor(sum*sum / (width*height)), where the product is exact in 64 bits and the result is taken modulo 2^32.
- R6: After a legal start, `px_ready` is high on every cycle until exactly width*height pixels have been accepted. It goes low on the cycle after the last accepted pixel.
- R7: `done` is high for one cycle when the results are updated. `sse_out` and `var_out` change only in that cycle and hold until the next result.
- R8: After reset, `px_ready`, `done` and `size_err` are low, and `sse_out` and `var_out` are zero.
- R9: Both accumulators are cleared when a legal start is taken, so a block's result does not depend on earlier blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled in idle |
| blk_w | input | 8 | Block width in pixels |
| blk_h | input | 8 | Block height in pixels |
| px_valid | input | 1 | Pixel data valid |
| px_ready | output | 1 | Engine accepts a pixel |
| px_pred | input | 8 | Predicted sample, unsigned |
| px_wsrc | input | 32 | Weighted source value, signed |
| px_mask | input | 32 | Mask weight, signed |
| size_err | output | 1 | One-cycle pulse for an illegal size |
| done | output | 1 | One-cycle pulse when results update |
| sse_out | output | 32 | Sum of squared scaled residuals |
| var_out | output | 32 | Block variance |

## Verification
The assertions assume that `start` is only pulsed while the engine is idle and not on consecutive cycles. They also assume the pixel stream supplies exactly width*height beats per block. The bench keeps to this: it pulses `start` for one cycle, waits for `done` or `size_err` before the next start, and drives `px_valid` only for the pixels of the current block, inserting random bubbles between them. The stimulus mixes residuals placed exactly on odd multiples of 2048, moderate random values and full-range values that wrap the 32-bit residual.

// File: rtl/wmv_pkg.sv
package wmv_pkg;
  localparam int PIX_W = 8;
  localparam int DAT_W = 32;
  localparam int DIM_W = 8;
  localparam int SHIFT = 12;
  localparam int CNT_W = 2 * DIM_W;
  localparam int RES_W = DAT_W + 1 - SHIFT;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DIV} wmv_state_e;

  // log2 of a power of two between 4 and 128, else zero
  function automatic logic [2:0] dim_log(input logic [DIM_W-1:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 2; i < 8; i++) begin
      if (v == (DIM_W'(1) << i)) r = 3'(i);
    end
    return r;
  endfunction

  function automatic logic size_ok(input logic [DIM_W-1:0] w, input logic [DIM_W-1:0] h);
    logic [2:0] lw, lh, dif;
    lw  = dim_log(w);
    lh  = dim_log(h);
    dif = (lw > lh) ? lw - lh : lh - lw;
    return (lw != 3'd0) && (lh != 3'd0) && (dif <= 3'd2) &&
           !((dif == 3'd2) && ((lw == 3'd7) || (lh == 3'd7)));
  endfunction
endpackage

// File: rtl/wmv_resid.sv
module wmv_resid #(
  parameter int PIX_W = wmv_pkg::PIX_W,
  parameter int DAT_W = wmv_pkg::DAT_W,
  parameter int SHIFT = wmv_pkg::SHIFT,
  localparam int RES_W = DAT_W + 1 - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [PIX_W-1:0] pred,
  input  logic [DAT_W-1:0] wsrc,
  input  logic [DAT_W-1:0] mask,
  output logic             busy,
  output logic             out_vld,
  output logic [RES_W-1:0] res
);
  localparam logic [DAT_W:0] HALF = (DAT_W+1)'(1) << (SHIFT - 1);

  logic             v1_q, v2_q;
  logic [DAT_W-1:0] d_q, d_d;
  logic [RES_W-1:0] r_q, r_d;
  logic [DAT_W:0]   bias;

  // stage 1: raw residual, modulo 2^DAT_W
  always_comb begin
    d_d = wsrc - DAT_W'({{(DAT_W-PIX_W){1'b0}}, pred} * mask);
  end

  // stage 2: negative values step down by one, then round half up
  always_comb begin
    bias = {d_q[DAT_W-1], d_q} + {(DAT_W+1){d_q[DAT_W-1]}} + HALF;
    r_d  = RES_W'($signed(bias) >>> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      d_q  <= '0;
      r_q  <= '0;
    end else begin
      v1_q <= in_vld;
      v2_q <= v1_q;
      if (in_vld) d_q <= d_d;
      if (v1_q)   r_q <= r_d;
    end
  end

  assign busy    = v1_q | v2_q;
  assign out_vld = v2_q;
  assign res     = r_q;
endmodule

// File: rtl/wmv_accum.sv
module wmv_accum #(
  parameter int DAT_W = wmv_pkg::DAT_W,
  parameter int RES_W = wmv_pkg::RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [RES_W-1:0] res,
  output logic [DAT_W-1:0] sum,
  output logic [DAT_W-1:0] sse
);
  logic [DAT_W-1:0] sum_q, sum_d, sse_q, sse_d;
  logic signed [2*RES_W-1:0] sq;

  always_comb begin
    sq    = $signed(res) * $signed(res);
    sum_d = sum_q;
    sse_d = sse_q;
    if (clr) begin
      sum_d = '0;
      sse_d = '0;
    end else if (en) begin
      sum_d = sum_q + {{(DAT_W-RES_W){res[RES_W-1]}}, res};
      sse_d = sse_q + DAT_W'(sq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sse_q <= '0;
    end else if (clr || en) begin
      sum_q <= sum_d;
      sse_q <= sse_d;
    end
  end

  assign sum = sum_q;
  assign sse = sse_q;
endmodule

// File: rtl/wmv_div.sv
module wmv_div #(
  parameter int NW = 64,
  parameter int DW = wmv_pkg::CNT_W,
  localparam int CW = $clog2(NW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          fin,
  output logic [NW-1:0] quo
);
  logic [DW:0]   rem_q, rem_d, rem_sh;
  logic [NW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, fin_q, fin_d, ge;

  always_comb begin
    rem_sh = {rem_q[DW-1:0], quo_q[NW-1]};
    ge     = rem_sh >= {1'b0, divisor};
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      quo_d  = dividend;
      cnt_d  = CW'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? rem_sh - {1'b0, divisor} : rem_sh;
      quo_d = {quo_q[NW-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (go || busy_q) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        cnt_q <= cnt_d;
      end
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign fin = fin_q;
  assign quo = quo_q;
endmodule

// File: rtl/wmv_top.sv
module wmv_top
  import wmv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] blk_w,
  input  logic [DIM_W-1:0] blk_h,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [PIX_W-1:0] px_pred,
  input  logic [DAT_W-1:0] px_wsrc,
  input  logic [DAT_W-1:0] px_mask,
  output logic             size_err,
  output logic             done,
  output logic [DAT_W-1:0] sse_out,
  output logic [DAT_W-1:0] var_out
);
  localparam int NW = 2 * DAT_W;

  wmv_state_e       st_q, st_d;
  logic [CNT_W-1:0] left_q, left_d, area_q, area_d, area;
  logic             err_d, err_q, done_d, done_q;
  logic [DAT_W-1:0] sse_o_q, sse_o_d, var_o_q, var_o_d;
  logic             accept, start_ok, div_go, div_fin, pipe_busy, res_vld;
  logic [RES_W-1:0] res;
  logic [DAT_W-1:0] sum, sse;
  logic signed [NW-1:0] sum_w, sum_sq;
  logic [NW-1:0]    quo;

  assign area     = CNT_W'(blk_w) * CNT_W'(blk_h);
  assign px_ready = (st_q == ST_RUN);
  assign accept   = px_valid && px_ready;
  assign start_ok = (st_q == ST_IDLE) && start && size_ok(blk_w, blk_h);
  assign sum_w    = {{DAT_W{sum[DAT_W-1]}}, sum};
  assign sum_sq   = sum_w * sum_w;

  wmv_resid u_resid (
    .clk(clk), .rst_n(rst_n), .in_vld(accept), .pred(px_pred),
    .wsrc(px_wsrc), .mask(px_mask), .busy(pipe_busy), .out_vld(res_vld), .res(res)
  );

  wmv_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(res_vld), .res(res),
    .sum(sum), .sse(sse)
  );

  wmv_div #(.NW(NW), .DW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(sum_sq),
    .divisor(area_q), .fin(div_fin), .quo(quo)
  );

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    area_d  = area_q;
    err_d   = 1'b0;
    done_d  = 1'b0;
    div_go  = 1'b0;
    sse_o_d = sse_o_q;
    var_o_d = var_o_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d   = ST_RUN;
          left_d = area;
          area_d = area;
        end else if (start) begin
          err_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (accept) begin
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!pipe_busy) begin
          div_go = 1'b1;
          st_d   = ST_DIV;
        end
      end
      ST_DIV: begin
        if (div_fin) begin
          sse_o_d = sse;
          var_o_d = sse - DAT_W'(quo);
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      left_q  <= '0;
      area_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      sse_o_q <= '0;
      var_o_q <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      done_q <= done_d;
      if (start_ok || accept) left_q <= left_d;
      if (start_ok) area_q <= area_d;
      if (done_d) begin
        sse_o_q <= sse_o_d;
        var_o_q <= var_o_d;
      end
    end
  end

  assign size_err = err_q;
  assign done     = done_q;
  assign sse_out  = sse_o_q;
  assign var_out  = var_o_q;
endmodule

// File: rtl/wmv_chk.sv
module wmv_chk #(
  parameter int DAT_W = wmv_pkg::DAT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             px_ready,
  input logic             size_err,
  input logic             done,
  input logic [DAT_W-1:0] sse_out,
  input logic [DAT_W-1:0] var_out
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(sse_out) && $stable(var_out)));

  // R1
  err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !px_ready);

  // R1
  err_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(size_err && done));

  // R6
  ready_off_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !px_ready);
endmodule

bind wmv_top wmv_chk #(.DAT_W(wmv_pkg::DAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .px_ready(px_ready), .size_err(size_err),
  .done(done), .sse_out(sse_out), .var_out(var_out)
);

// File: tb/sim_wmv_top.sv
`timescale 1ns/1ps
module sim_wmv_top;
  logic        clk = 1'b0;
  logic        rst_n, start, px_valid, px_ready, size_err, done;
  logic [7:0]  blk_w, blk_h, px_pred;
  logic [31:0] px_wsrc, px_mask, sse_out, var_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  wmv_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_w(blk_w), .blk_h(blk_h),
    .px_valid(px_valid), .px_ready(px_ready), .px_pred(px_pred),
    .px_wsrc(px_wsrc), .px_mask(px_mask), .size_err(size_err), .done(done),
    .sse_out(sse_out), .var_out(var_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint round_away(input longint d);
    longint m, q;
    m = (d < 0) ? -d : d;
    q = (m + 2048) / 4096;
    return (d < 0) ? -q : q;
  endfunction

  task automatic bad_start(input int w, input int h);
    logic [31:0] s0, v0;
    s0 = sse_out;
    v0 = var_out;
    @(negedge clk);
    start = 1'b1; blk_w = 8'(w); blk_h = 8'(h);
    @(negedge clk);
    start = 1'b0;
    check(size_err == 1'b1, "R1 size_err pulse", longint'(size_err), 1);
    check(px_ready == 1'b0, "R1 no run on bad size", longint'(px_ready), 0);
    @(negedge clk);
    check(size_err == 1'b0, "R1 size_err one cycle", longint'(size_err), 0);
    check(sse_out == s0 && var_out == v0, "R1 outputs kept", longint'(sse_out), longint'(s0));
  endtask

  // mode 0 moderate random, 1 exact ties, 2 full-range wrap
  task automatic run_block(input int w, input int h, input int mode, input bit bubbles);
    int          e_sum;
    int unsigned e_sse, e_var, q;
    int          stalls, t;
    string       tag;
    e_sum = 0; e_sse = 0; stalls = 0;
    tag = (mode == 1) ? "R3" : ((mode == 2) ? "R2" : "R4");
    @(negedge clk);
    start = 1'b1; blk_w = 8'(w); blk_h = 8'(h);
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < w * h; p++) begin
      int pre, msk, ws, d;
      longint r;
      pre = int'($urandom_range(0, 255));
      if (mode == 0) begin
        msk = int'($urandom_range(0, 4096));
        ws  = pre * msk + int'($urandom_range(0, 2097152)) - 1048576;
      end else if (mode == 1) begin
        msk = int'($urandom_range(0, 64));
        ws  = pre * msk + (int'($urandom_range(0, 600)) - 300) * 4096 +
              (($urandom_range(0, 1) == 1) ? 2048 : -2048);
      end else begin
        msk = int'($urandom());
        ws  = int'($urandom());
      end
      if (bubbles && $urandom_range(0, 3) == 0) begin
        px_valid = 1'b0;
        @(negedge clk);
      end
      px_valid = 1'b1; px_pred = 8'(pre); px_wsrc = ws; px_mask = msk;
      while (!px_ready && stalls < 100) begin
        stalls++;
        @(negedge clk);
      end
      @(negedge clk);
      d = ws - pre * msk;
      r = round_away(longint'(d));
      e_sum = e_sum + int'(r);
      e_sse = e_sse + 32'(r * r);
    end
    px_valid = 1'b0;
    check(stalls == 0, "R6 ready held through block", stalls, 0);
    check(px_ready == 1'b0, "R6 ready drops after last pixel", longint'(px_ready), 0);
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R7 done pulse seen", longint'(done), 1);
    q     = 32'((longint'(e_sum) * longint'(e_sum)) / longint'(w * h));
    e_var = e_sse - q;
    check(sse_out == e_sse, {tag, " sse"}, longint'(sse_out), longint'(e_sse));
    check(var_out == e_var, "R5 variance", longint'(var_out), longint'(e_var));
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", longint'(done), 0);
    check(sse_out == e_sse && var_out == e_var, "R7 outputs held",
          longint'(var_out), longint'(e_var));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd918273));
    rst_n = 1'b0; start = 1'b0; px_valid = 1'b0;
    blk_w = '0; blk_h = '0; px_pred = '0; px_wsrc = '0; px_mask = '0;
    repeat (3) @(negedge clk);
    check(px_ready == 1'b0 && done == 1'b0 && size_err == 1'b0, "R8 reset flags",
          longint'({px_ready, done, size_err}), 0);
    check(sse_out == 0 && var_out == 0, "R8 reset outputs", longint'(sse_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    bad_start(4, 32);
    bad_start(128, 32);
    bad_start(6, 8);
    bad_start(0, 4);
    bad_start(16, 2);

    run_block(4, 4, 1, 1'b0);
    run_block(8, 8, 0, 1'b1);
    run_block(16, 4, 0, 1'b1);
    run_block(4, 16, 2, 1'b1);
    run_block(8, 32, 1, 1'b1);
    // R9: back-to-back blocks start from cleared totals
    run_block(4, 8, 0, 1'b0);
    run_block(32, 64, 2, 1'b0);
    bad_start(64, 8);
    run_block(64, 128, 1, 1'b0);
    run_block(128, 128, 0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule